// File: doc/BRIEF.md
# Fuse-Programmed Product-Term Array

This block is the programmable AND-OR plane of a 26-input, 12-output logic device. Its configuration lives in a fuse image that is written one bit at a time by linear address. The image holds 150 product-term rows of 52 columns, per-macrocell mode bits, a 64-bit user signature and a sticky security flag. Each of the 52 columns carries either the true or the complemented form of one of the 26 input or feedback signals.

The 150 rows are grouped into fixed blocks. The first row is a shared asynchronous-reset term and the last row is a shared synchronous-preset term. Between them, each output owns one enable row followed by its logic rows. The outputs have unequal term budgets, from 8 to 16 terms. The logic rows of an output are ORed into its sum term. The macrocell registers and the pads are outside this block and consume the sum, enable, reset, preset and mode-bit outputs.

A registered readback port returns any stored bit one cycle after its address is presented. When the security flag is set, readback of the row fuses and the mode bits returns 0, while the signature stays readable. A bulk erase is the only way to clear the security flag.

Top module: `pta_top`

## Requirements
- R1: After reset or bulk erase (`cfg_erase`), every row fuse is intact (stored 1), and all mode bits, signature bits and the security flag are 0. As a result, `sum_o`, `oe_o`, `ar_o` and `sp_o` are all 0 for any input.
- R2: Column 2k is `in_sig[k]` and column 2k+1 is its complement. An intact fuse (1) includes its column in the AND, and a blown fuse (0) leaves it out. A row with every fuse blown evaluates to 1.
- R3: Row fuse r, column c sits at linear address 52*r + c, for addresses 0 to 7799. A write is stored on the clock edge at which `cfg_we` is high and takes effect on the combinational outputs in the following cycle.
- R4: Row 0 drives `ar_o` and row 149 (base address 7748) drives `sp_o`.
- R5: Output o owns a block of 1+N rows. The first row of the block is its enable term (`oe_o[o]`) and the next N rows are ORed into `sum_o[o]`. N for outputs 0 to 11 is 8,8,10,12,14,16,16,14,12,10,8,8. Blocks follow one another from row 1 upward in output order.
- R6: Mode bit f (0 to 3) of macrocell m is stored at address 7800 + 12*f + m and appears on `arch_o[12*f + m]`.
- R7: Signature bit i is stored at address 7848 + i (i from 0 to 63) and reads back whether or not the security flag is set.
- R8: `cfg_rbit` returns the bit at `cfg_addr` one clock cycle after the address is presented.
- R9: Writing 1 to address 7912 sets the security flag, which reads back at 7912. While the flag is set, reads of addresses 0 to 7847 return 0.
- R10: Writing 0 to address 7912 has no effect. Once set, the security flag stays set until a bulk erase or reset.
- R11: Writes to addresses above 7912 are ignored, and reads of those addresses return 0.
- R12: When `cfg_erase` and `cfg_we` are both high in the same cycle, the erase wins and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_sig | input | 26 | Input and feedback signals feeding the columns |
| cfg_erase | input | 1 | Bulk erase of the whole fuse image |
| cfg_we | input | 1 | Write strobe for one fuse bit |
| cfg_addr | input | 13 | Linear fuse address for write and read |
| cfg_wbit | input | 1 | Bit value to write |
| cfg_rbit | output | 1 | Readback bit, one cycle after the address |
| sum_o | output | 12 | Per-output OR of its logic terms |
| oe_o | output | 12 | Per-output enable term |
| ar_o | output | 1 | Shared asynchronous-reset term |
| sp_o | output | 1 | Shared synchronous-preset term |
| arch_o | output | 48 | Mode bits, bit 12*f+m = field f of macrocell m |

## Verification
A fuse written to the wrong row or block shows up in the very next cycle: a foreign bit rises on `sum_o`, `oe_o`, `ar_o` or `sp_o`, or an expected bit fails to rise when the bench blows one whole row. Mistakes in address decoding or masking show up on `cfg_rbit` one cycle after the read address is presented. The bench therefore checks a read of each region before and after security is set, and again after erase. A security flag that can be cleared, or an erase that loses to a write, shows up as a stale 1 on readback or on `arch_o`.

// File: rtl/pta_pkg.sv
// Package: shared sizes, address map and row layout of the product-term array.
// Assumes the fixed 12-output budget table; all derived values are computed.
package pta_pkg;
    localparam int NUM_IN   = 26;
    localparam int NUM_OUT  = 12;
    localparam int COLS     = 2 * NUM_IN;
    localparam int MODE_F   = 4;
    localparam int SIG_BITS = 64;
    localparam int AW       = 13;

    // Logic-term budget of output o.
    function automatic int terms_of(input int o);
        case (o)
            0, 1, 10, 11: return 8;
            2, 9:         return 10;
            3, 8:         return 12;
            4, 7:         return 14;
            default:      return 16;
        endcase
    endfunction

    // Row index of the enable term of output o (row 0 is the reset term).
    function automatic int oe_row(input int o);
        int r;
        r = 1;
        for (int j = 0; j < o; j++) r += terms_of(j) + 1;
        return r;
    endfunction

    localparam int ROWS      = oe_row(NUM_OUT) + 1;
    localparam int SP_ROW    = ROWS - 1;
    localparam int ARR_END   = ROWS * COLS;
    localparam int ARCH_BASE = ARR_END;
    localparam int ARCH_BITS = MODE_F * NUM_OUT;
    localparam int SIG_BASE  = ARCH_BASE + ARCH_BITS;
    localparam int SEC_ADDR  = SIG_BASE + SIG_BITS;
    localparam int RW        = $clog2(ROWS);
    localparam int CW        = $clog2(COLS);
    localparam int XW        = $clog2(ARCH_BITS);
    localparam int SW        = $clog2(SIG_BITS);
endpackage

// File: rtl/pta_store.sv
// Fuse image: row fuses, mode bits, signature and security flag.
// Assumes one write per cycle; erase and reset load the intact/blank image.
module pta_store
    import pta_pkg::*;
#(
    parameter int P_ROWS = ROWS,
    parameter int P_COLS = COLS
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           erase,
    input  logic                           we,
    input  logic [AW-1:0]                  addr,
    input  logic                           wbit,
    output logic [P_ROWS-1:0][P_COLS-1:0]  fuse_o,
    output logic [ARCH_BITS-1:0]           arch_o,
    output logic                           sec_o,
    output logic                           rbit_o
);
    localparam logic [AW-1:0] A_ARCH = AW'(ARCH_BASE);
    localparam logic [AW-1:0] A_SIG  = AW'(SIG_BASE);
    localparam logic [AW-1:0] A_SEC  = AW'(SEC_ADDR);

    logic [P_ROWS-1:0][P_COLS-1:0] fuse_q;
    logic [ARCH_BITS-1:0]          arch_q;
    logic [SIG_BITS-1:0]           sig_q;
    logic                          sec_q;
    logic                          is_arr, is_arch, is_sig, is_sec;
    logic [RW-1:0]                 row_idx;
    logic [CW-1:0]                 col_idx;
    logic [XW-1:0]                 arch_idx;
    logic [SW-1:0]                 sig_idx;

    // Decode the linear address into region and in-region index.
    always_comb begin
        is_arr   = addr < A_ARCH;
        is_arch  = (addr >= A_ARCH) && (addr < A_SIG);
        is_sig   = (addr >= A_SIG) && (addr < A_SEC);
        is_sec   = addr == A_SEC;
        row_idx  = RW'(addr / AW'(P_COLS));
        col_idx  = CW'(addr % AW'(P_COLS));
        arch_idx = XW'(addr - A_ARCH);
        sig_idx  = SW'(addr - A_SIG);
    end

    // Store one bit per write; erase has priority and the flag only sets.
    always_ff @(posedge clk) begin
        if (!rst_n || erase) begin
            fuse_q <= '1;
            arch_q <= '0;
            sig_q  <= '0;
            sec_q  <= 1'b0;
        end else if (we) begin
            if (is_arr)
                fuse_q[row_idx][col_idx] <= wbit;
            else if (is_arch)
                arch_q[arch_idx] <= wbit;
            else if (is_sig)
                sig_q[sig_idx] <= wbit;
            else if (is_sec && wbit)
                sec_q <= 1'b1;
        end
    end

    // Registered readback with masking of functional bits under security.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rbit_o <= 1'b0;
        else if (is_arr)
            rbit_o <= !sec_q && fuse_q[row_idx][col_idx];
        else if (is_arch)
            rbit_o <= !sec_q && arch_q[arch_idx];
        else if (is_sig)
            rbit_o <= sig_q[sig_idx];
        else if (is_sec)
            rbit_o <= sec_q;
        else
            rbit_o <= 1'b0;
    end

    assign fuse_o = fuse_q;
    assign arch_o = arch_q;
    assign sec_o  = sec_q;
endmodule

// File: rtl/pta_term.sv
// One product term: AND of every column whose fuse is intact.
// Assumes fuse bit 1 = connected; an all-blown row yields 1.
module pta_term #(
    parameter int P_COLS = 52
) (
    input  logic [P_COLS-1:0] fuse_i,
    input  logic [P_COLS-1:0] col_i,
    output logic              term_o
);
    // A blown fuse forces its column to a neutral 1.
    assign term_o = &(~fuse_i | col_i);
endmodule

// File: rtl/pta_plane.sv
// Evaluates all rows and groups them into enable, sum, reset and preset terms.
// Assumes the row layout given by the package functions.
module pta_plane
    import pta_pkg::*;
#(
    parameter int P_ROWS = ROWS,
    parameter int P_COLS = COLS,
    parameter int P_OUT  = NUM_OUT
) (
    input  logic [P_ROWS-1:0][P_COLS-1:0] fuse_i,
    input  logic [P_COLS-1:0]             col_i,
    output logic [P_OUT-1:0]              sum_o,
    output logic [P_OUT-1:0]              oe_o,
    output logic                          ar_o,
    output logic                          sp_o
);
    logic [P_ROWS-1:0] pt;

    // One term evaluator per row.
    for (genvar r = 0; r < P_ROWS; r++) begin : g_row
        pta_term #(.P_COLS(P_COLS)) u_term (
            .fuse_i (fuse_i[r]),
            .col_i  (col_i),
            .term_o (pt[r])
        );
    end

    // Per-output grouping: enable row first, then its logic rows.
    for (genvar o = 0; o < P_OUT; o++) begin : g_out
        localparam int B = oe_row(o);
        localparam int N = terms_of(o);
        assign oe_o[o]  = pt[B];
        assign sum_o[o] = |pt[B+N:B+1];
    end

    assign ar_o = pt[0];
    assign sp_o = pt[P_ROWS-1];
endmodule

// File: rtl/pta_top.sv
// Top of the product-term array: column drivers, fuse image and plane.
// Assumes in_sig is already synchronous to clk where it feeds registers.
module pta_top
    import pta_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_IN-1:0]     in_sig,
    input  logic                  cfg_erase,
    input  logic                  cfg_we,
    input  logic [AW-1:0]         cfg_addr,
    input  logic                  cfg_wbit,
    output logic                  cfg_rbit,
    output logic [NUM_OUT-1:0]    sum_o,
    output logic [NUM_OUT-1:0]    oe_o,
    output logic                  ar_o,
    output logic                  sp_o,
    output logic [ARCH_BITS-1:0]  arch_o
);
    logic [COLS-1:0]            col_vec;
    logic [ROWS-1:0][COLS-1:0]  fuse_w;
    logic                       sec_w;

    // True and complement column pair per input signal.
    for (genvar k = 0; k < NUM_IN; k++) begin : g_col
        assign col_vec[2*k]   = in_sig[k];
        assign col_vec[2*k+1] = ~in_sig[k];
    end

    pta_store #(.P_ROWS(ROWS), .P_COLS(COLS)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .erase  (cfg_erase),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wbit   (cfg_wbit),
        .fuse_o (fuse_w),
        .arch_o (arch_o),
        .sec_o  (sec_w),
        .rbit_o (cfg_rbit)
    );

    pta_plane #(.P_ROWS(ROWS), .P_COLS(COLS), .P_OUT(NUM_OUT)) u_plane (
        .fuse_i (fuse_w),
        .col_i  (col_vec),
        .sum_o  (sum_o),
        .oe_o   (oe_o),
        .ar_o   (ar_o),
        .sp_o   (sp_o)
    );
endmodule

// File: rtl/pta_chk.sv
// Checker for pta_top: erase, security and mode-bit write properties.
module pta_chk
    import pta_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_erase,
    input logic                 cfg_we,
    input logic [AW-1:0]        cfg_addr,
    input logic                 cfg_wbit,
    input logic                 cfg_rbit,
    input logic [NUM_OUT-1:0]   sum_o,
    input logic [NUM_OUT-1:0]   oe_o,
    input logic                 ar_o,
    input logic                 sp_o,
    input logic [ARCH_BITS-1:0] arch_o,
    input logic                 sec_q
);
    localparam logic [AW-1:0] A_ARCH = AW'(ARCH_BASE);
    localparam logic [AW-1:0] A_SIG  = AW'(SIG_BASE);

    a_r9_secure_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_q && cfg_addr < A_SIG) |=> !cfg_rbit);

    a_r12_erase_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_erase |=> (arch_o == '0 && !sec_q));

    a_r1_erase_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_erase |=> (sum_o == '0 && oe_o == '0 && !ar_o && !sp_o));

    a_r6_arch_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_erase && cfg_addr >= A_ARCH && cfg_addr < A_SIG)
        |=> arch_o[XW'($past(cfg_addr) - A_ARCH)] == $past(cfg_wbit));

    a_r10_sec_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sec_q) |-> $past(cfg_erase));
endmodule

bind pta_top pta_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_erase (cfg_erase),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wbit  (cfg_wbit),
    .cfg_rbit  (cfg_rbit),
    .sum_o     (sum_o),
    .oe_o      (oe_o),
    .ar_o      (ar_o),
    .sp_o      (sp_o),
    .arch_o    (arch_o),
    .sec_q     (sec_w)
);

// File: tb/pta_top_bench.sv
`timescale 1ns/1ps
module pta_top_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [25:0] in_sig;
    logic        cfg_erase, cfg_we, cfg_wbit, cfg_rbit;
    logic [12:0] cfg_addr;
    logic [11:0] sum_o, oe_o;
    logic        ar_o, sp_o;
    logic [47:0] arch_o;

    typedef struct { logic exp; int addr; string tag; } rd_item_t;
    rd_item_t rq[$];
    logic rd_issue = 1'b0;
    int checks = 0, fails = 0;
    bit done = 0;
    int nt[12] = '{8, 8, 10, 12, 14, 16, 16, 14, 12, 10, 8, 8};

    always #2 clk = ~clk;

    pta_top u_pta_top (
        .clk(clk), .rst_n(rst_n), .in_sig(in_sig), .cfg_erase(cfg_erase),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wbit(cfg_wbit),
        .cfg_rbit(cfg_rbit), .sum_o(sum_o), .oe_o(oe_o), .ar_o(ar_o),
        .sp_o(sp_o), .arch_o(arch_o)
    );

    task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int oe_base(input int o);
        int r = 1;
        for (int j = 0; j < o; j++) r += nt[j] + 1;
        return r;
    endfunction

    task automatic wr(input int a, input logic b);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 13'(a); cfg_wbit = b;
    endtask

    task automatic idle();
        @(negedge clk);
        cfg_we = 1'b0; cfg_erase = 1'b0;
        #1;
    endtask

    task automatic wr_row(input int r, input logic [51:0] v);
        for (int c = 0; c < 52; c++) wr(r * 52 + c, v[c]);
        idle();
    endtask

    // Driver: present a read address and push the expected bit.
    task automatic rd(input int a, input logic e, input string tag);
        rd_item_t it;
        @(negedge clk);
        cfg_we = 1'b0; cfg_addr = 13'(a);
        it.exp = e; it.addr = a; it.tag = tag;
        rq.push_back(it);
        rd_issue = 1'b1;
        @(posedge clk);
        #2 rd_issue = 1'b0;
    endtask

    // Monitor: one cycle after the address, compare readback (R8).
    always @(posedge clk) begin
        if (rd_issue) begin
            rd_item_t it;
            #1;
            it = rq.pop_front();
            chk(cfg_rbit === it.exp, it.tag, 64'(cfg_rbit), 64'(it.exp));
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; in_sig = '0; cfg_erase = 1'b0; cfg_we = 1'b0;
        cfg_addr = '0; cfg_wbit = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(sum_o == 0 && oe_o == 0 && !ar_o && !sp_o, "R1 terms after reset",
            {sum_o, oe_o, ar_o, sp_o}, 0);
        chk(arch_o == 0 && cfg_rbit == 0, "R1 mode bits after reset", arch_o, 0);
        rd(0, 1'b1, "R1 fuse intact readback (R8)");
        rd(7848, 1'b0, "R1 signature cleared");

        // R4 reset row, all blown
        wr_row(0, '0);
        chk(ar_o && sum_o == 0 && oe_o == 0, "R4 all-blown row 0 drives ar_o",
            {sum_o, oe_o, ar_o}, 1);
        // R2 column pairing: ar = in3 & ~in5
        wr_row(0, 52'((64'd1 << 6) | (64'd1 << 11)));
        in_sig = 26'(1 << 3); #1;
        chk(ar_o == 1'b1, "R2 true column, other off", ar_o, 1);
        in_sig = 26'((1 << 3) | (1 << 5)); #1;
        chk(ar_o == 1'b0, "R2 complement column kills term", ar_o, 0);
        in_sig = '0; #1;
        chk(ar_o == 1'b0, "R2 true column low", ar_o, 0);
        in_sig = ~26'(1 << 5); #1;
        chk(ar_o == 1'b1, "R2 other inputs ignored", ar_o, 1);
        wr_row(0, '1);
        chk(ar_o == 1'b0, "R2 all-intact row is 0", ar_o, 0);

        // R4 preset row and R3 address map
        wr_row(149, '0);
        chk(sp_o && !ar_o && sum_o == 0, "R4 last row drives sp_o", {sum_o, ar_o, sp_o}, 1);
        rd(7748, 1'b0, "R3 row 149 col 0 at 7748");
        rd(7747, 1'b1, "R3 row 148 col 51 untouched");
        wr_row(149, '1);
        chk(!sp_o, "R4 preset row restored", sp_o, 0);

        // R5 block layout
        foreach (nt[o]) begin
            if (o == 0 || o == 5 || o == 11) begin
                wr_row(oe_base(o) + nt[o], '0);
                chk(sum_o == 12'(1 << o) && oe_o == 0, "R5 last logic row of output",
                    {sum_o, oe_o}, 64'(1 << o) << 12);
                wr_row(oe_base(o) + nt[o], '1);
            end
        end
        wr_row(oe_base(3) + 1, '0);
        chk(sum_o == 12'(1 << 3) && oe_o == 0, "R5 first logic row of output 3",
            {sum_o, oe_o}, 64'(1 << 3) << 12);
        wr_row(oe_base(3) + 1, '1);
        wr_row(oe_base(6), '0);
        chk(oe_o == 12'(1 << 6) && sum_o == 0, "R5 enable row of output 6",
            {sum_o, oe_o}, 64'(1 << 6));
        wr_row(oe_base(6), '1);

        // R6 mode bits
        wr(7831, 1'b1); idle();
        chk(arch_o == 48'(64'd1 << 31), "R6 field 2 macrocell 7", arch_o, 64'd1 << 31);
        rd(7831, 1'b1, "R6 mode bit readback");

        // R7 signature
        wr(7848, 1'b1); wr(7911, 1'b1); idle();
        rd(7848, 1'b1, "R7 signature bit 0");
        rd(7911, 1'b1, "R7 signature bit 63");
        rd(7880, 1'b0, "R7 signature bit 32 clear");

        // R9 security
        wr(7912, 1'b1); idle();
        rd(7912, 1'b1, "R9 security flag reads 1");
        rd(7831, 1'b0, "R9 mode bit masked");
        rd(0, 1'b0, "R9 fuse masked");
        rd(7848, 1'b1, "R7 signature readable while secure");
        rd(7911, 1'b1, "R7 signature top bit while secure");

        // R10 sticky
        wr(7912, 1'b0); idle();
        rd(7912, 1'b1, "R10 flag not cleared by write");
        rd(100, 1'b0, "R10 fuse still masked");

        // R11 out of range
        wr(7950, 1'b1); idle();
        rd(7950, 1'b0, "R11 out-of-range read");
        chk(arch_o == 48'(64'd1 << 31), "R11 write did not disturb mode bits",
            arch_o, 64'd1 << 31);

        // R12 erase beats write
        @(negedge clk);
        cfg_erase = 1'b1; cfg_we = 1'b1; cfg_addr = 13'd7830; cfg_wbit = 1'b1;
        idle();
        chk(arch_o == 0, "R12 erase beats same-cycle write", arch_o, 0);
        chk(sum_o == 0 && oe_o == 0 && !ar_o && !sp_o, "R1 terms after erase",
            {sum_o, oe_o, ar_o, sp_o}, 0);
        rd(7912, 1'b0, "R1 security cleared by erase");
        rd(7830, 1'b0, "R12 dropped write");
        rd(5, 1'b1, "R1 fuse intact after erase");
        rd(7848, 1'b0, "R1 signature cleared by erase");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule